// File: doc/BRIEF.md
# Streaming SHA-256 Hasher with Built-In Padding

This block computes the SHA-256 digest of a byte stream whose total size is announced up front. A caller pulses a load strobe together with the byte count, then pushes the raw message one byte per write into an internal byte buffer. The block appends the standard message padding on its own: the marker byte, the zero fill and the 64-bit bit count. The caller therefore never sees or builds padded blocks.

Internally, a feeder pulls bytes from the buffer, or makes pad bytes once the message is exhausted, into a 512-bit staging block. A round engine compresses the previous block while the next one is being gathered. With data ready, each block costs 65 cycles. The finished digest appears for one cycle together with a valid strobe, and the busy flag drops on the following cycle.

Top module: `sha256_stream`

## Requirements
- R1: After the active-low reset, `busy` and `digest_valid` are 0, `buf_empty` is 1 and `buf_count` is 0.
- R2: A `len_load` pulse while idle captures `len_bytes` in the same cycle. `busy` is 1 from the next cycle up to and including the `digest_valid` cycle, and 0 in the cycle after it.
- R3: `digest_valid` is high for exactly one cycle. During that cycle `digest` holds the SHA-256 value of the declared bytes. Message words are taken big-endian from the byte order of writes, and the first hash word sits in bits 255:224 (the 3-byte message 61 62 63 gives ba7816bf...f20015ad).
- R4: After the last message byte, the block inserts 0x80, then zeros, then the bit length as a 64-bit big-endian value ending the final block. A second padded block is added when 56 or more bytes of the last block are message bytes: lengths 55, 56 and 64 give 1, 2 and 2 blocks.
- R5: A declared length of 0 gives one padded block and the digest e3b0c442...7852b855.
- R6: Each cycle with `wr_en` high stores `wr_byte` in the buffer. `buf_count` gives the number of stored bytes, and `buf_empty` is 1 exactly when that number is 0.
- R7: With all message bytes already buffered, `digest_valid` rises 65*N+64 clock edges after the edge that accepts `len_load`, where N = floor((len+8)/64)+1 is the block count.
- R8: When the buffer runs dry mid-message, hashing waits for further bytes and the digest is still correct for any gap pattern between writes.
- R9: A `len_load` pulse while `busy` is 1 is ignored: the running hash finishes with its original length and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| len_load | input | 1 | Start strobe; captures the length |
| len_bytes | input | 61 | Message length in bytes |
| wr_en | input | 1 | Byte write enable |
| wr_byte | input | 8 | Message byte |
| buf_empty | output | 1 | Buffer holds no bytes |
| buf_count | output | 11 | Bytes held in the buffer |
| busy | output | 1 | Hash in progress |
| digest_valid | output | 1 | One-cycle digest strobe |
| digest | output | 256 | SHA-256 result, first word in the top bits |

## Verification
The zero-length message and the three-byte message are compared against fixed published digests, which exposes wrong constants, word order or padding marker. Lengths 55, 56 and 64 sit on either side of the point where the length field no longer fits, so they separate one-block from two-block padding. A 300-byte prefilled run and the short prefilled runs pin the exact cycle of the strobe and so the 65-cycle block rate. A 200-byte run with gaps between writes, plus a stray load pulse mid-hash, shows that stalls and ignored restarts leave the digest unchanged. Every digest is also checked against a reference computed in the bench with a full 64-word schedule.

// File: rtl/sha_stream_pkg.sv
package sha_stream_pkg;
  localparam int LEN_W = 61;
  localparam int BLK_W = 512;
  localparam int DIG_W = 256;

  localparam logic [DIG_W-1:0] IV = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  localparam logic [31:0] K_TAB [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  function automatic logic [31:0] ror(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] big_s0(input logic [31:0] x);
    return ror(x, 2) ^ ror(x, 13) ^ ror(x, 22);
  endfunction

  function automatic logic [31:0] big_s1(input logic [31:0] x);
    return ror(x, 6) ^ ror(x, 11) ^ ror(x, 25);
  endfunction

  function automatic logic [31:0] sml_s0(input logic [31:0] x);
    return ror(x, 7) ^ ror(x, 18) ^ (x >> 3);
  endfunction

  function automatic logic [31:0] sml_s1(input logic [31:0] x);
    return ror(x, 17) ^ ror(x, 19) ^ (x >> 10);
  endfunction

  // One compression round on the packed working state {a,b,c,d,e,f,g,h}
  function automatic logic [DIG_W-1:0] round_step(input logic [DIG_W-1:0] st,
                                                  input logic [31:0] kw);
    logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
    {a, b, c, d, e, f, g, h} = st;
    t1 = h + big_s1(e) + ((e & f) ^ (~e & g)) + kw;
    t2 = big_s0(a) + ((a & b) ^ (a & c) ^ (b & c));
    return {t1 + t2, a, b, c, d + t1, e, f, g};
  endfunction

  function automatic logic [31:0] sched_next(input logic [31:0] w0, input logic [31:0] w1,
                                             input logic [31:0] w9, input logic [31:0] w14);
    return sml_s1(w14) + w9 + sml_s0(w1) + w0;
  endfunction

  function automatic logic [DIG_W-1:0] add_lanes(input logic [DIG_W-1:0] x,
                                                 input logic [DIG_W-1:0] y);
    logic [DIG_W-1:0] r;
    for (int i = 0; i < 8; i++) r[32*i +: 32] = x[32*i +: 32] + y[32*i +: 32];
    return r;
  endfunction

  // Index of the last byte of the padded stream for a message of len bytes
  function automatic logic [63:0] pad_end(input logic [LEN_W-1:0] len);
    return (64'(len) + 64'd8) | 64'd63;
  endfunction

  // Byte at stream position idx once the message (len bytes) is exhausted
  function automatic logic [7:0] pad_byte(input logic [63:0] idx, input logic [LEN_W-1:0] len);
    logic [63:0] bits, k;
    bits = 64'(len) << 3;
    k = pad_end(len) - idx;
    if (idx == 64'(len)) return 8'h80;
    else if (k < 64'd8) return bits[{k[2:0], 3'b000} +: 8];
    else return 8'h00;
  endfunction
endpackage

// File: rtl/sha_byte_fifo.sv
module sha_byte_fifo #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [7:0]    wdata,
  input  logic          rd,
  output logic [7:0]    rdata,
  output logic          empty,
  output logic [AW-1:0] count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, wr_ok, rd_ok;

  assign full  = (count == {AW{1'b1}});
  assign empty = (count == '0);
  assign wr_ok = wr && !full;
  assign rd_ok = rd && !empty;
  assign rdata = mem[rp];

  always_ff @(posedge clk) if (wr_ok) mem[wp] <= wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) rp <= rp + 1'b1;
      if (wr_ok && !rd_ok) count <= count + 1'b1;
      else if (rd_ok && !wr_ok) count <= count - 1'b1;
    end
  end

  a_r6_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !rd && !full) |=> (count == $past(count) + 1'b1));
  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr && !empty) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/sha_block_feeder.sv
module sha_block_feeder
  import sha_stream_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LEN_W-1:0] len,
  input  logic [7:0]       byte_in,
  input  logic             fifo_empty,
  input  logic             take,
  output logic             fifo_rd,
  output logic             blk_valid,
  output logic [BLK_W-1:0] blk,
  output logic             blk_first,
  output logic             blk_last
);
  logic             active, full;
  logic [63:0]      idx;
  logic [LEN_W-1:0] len_q;
  logic             need_data, can_shift, blk_done;
  logic [7:0]       nbyte;

  assign need_data = idx < 64'(len_q);
  assign fifo_rd   = active && !full && need_data && !fifo_empty;
  assign can_shift = active && !full && (!need_data || !fifo_empty);
  assign nbyte     = need_data ? byte_in : pad_byte(idx, len_q);
  assign blk_valid = full;
  assign blk_last  = (idx == pad_end(len_q) + 64'd1);
  assign blk_done  = full && take;

  always_ff @(posedge clk) if (can_shift) blk <= {blk[BLK_W-9:0], nbyte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; full <= 1'b0; blk_first <= 1'b0; idx <= '0; len_q <= '0;
    end else if (go) begin
      active <= 1'b1; full <= 1'b0; blk_first <= 1'b1; idx <= '0; len_q <= len;
    end else begin
      if (can_shift) begin
        idx <= idx + 64'd1;
        if (idx[5:0] == 6'd63) full <= 1'b1;
      end
      if (blk_done) begin
        full <= 1'b0;
        blk_first <= 1'b0;
        if (blk_last) active <= 1'b0;
      end
    end
  end

  a_r4_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> (idx[5:0] == 6'd0));
  a_r4_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && blk_last && !go) |=> !active);
  a_r8_hold_while_dry: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !full && need_data && fifo_empty && !go) |=> $stable(idx));
endmodule

// File: rtl/sha_round_core.sv
module sha_round_core
  import sha_stream_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             first,
  input  logic             last,
  input  logic [BLK_W-1:0] blk,
  output logic             ready,
  output logic             fin,
  output logic [DIG_W-1:0] digest
);
  logic             running, last_q;
  logic [5:0]       cnt;
  logic [DIG_W-1:0] st, hreg, nst;
  logic [31:0]      win [16];
  logic [31:0]      nw;

  assign ready  = !running;
  assign digest = hreg;
  assign nst    = round_step(st, K_TAB[cnt] + win[0]);
  assign nw     = sched_next(win[0], win[1], win[9], win[14]);

  always_ff @(posedge clk) begin
    if (start) begin
      for (int i = 0; i < 16; i++) win[i] <= blk[BLK_W-1-32*i -: 32];
    end else if (running) begin
      for (int i = 0; i < 15; i++) win[i] <= win[i+1];
      win[15] <= nw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0; last_q <= 1'b0; cnt <= '0; fin <= 1'b0;
      st <= '0; hreg <= '0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        running <= 1'b1;
        cnt <= '0;
        last_q <= last;
        st <= first ? IV : hreg;
        if (first) hreg <= IV;
      end else if (running) begin
        st <= nst;
        cnt <= cnt + 1'b1;
        if (cnt == 6'd63) begin
          running <= 1'b0;
          hreg <= add_lanes(hreg, nst);
          fin <= last_q;
        end
      end
    end
  end

  a_r7_fin_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> ($past(running) && $past(cnt) == 6'd63));
  a_r7_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> ($past(cnt) == 6'd63));
  a_r7_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !running);
endmodule

// File: rtl/sha256_stream.sv
module sha256_stream
  import sha_stream_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int CNT_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_load,
  input  logic [LEN_W-1:0] len_bytes,
  input  logic             wr_en,
  input  logic [7:0]       wr_byte,
  output logic             buf_empty,
  output logic [CNT_W-1:0] buf_count,
  output logic             busy,
  output logic             digest_valid,
  output logic [DIG_W-1:0] digest
);
  logic             go, fifo_rd, blk_valid, blk_first, blk_last, core_ready, start;
  logic [7:0]       fifo_byte;
  logic [BLK_W-1:0] blk;

  assign go    = len_load && !busy;
  assign start = blk_valid && core_ready;

  sha_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr(wr_en), .wdata(wr_byte), .rd(fifo_rd),
    .rdata(fifo_byte), .empty(buf_empty), .count(buf_count));

  sha_block_feeder u_feed (
    .clk(clk), .rst_n(rst_n), .go(go), .len(len_bytes), .byte_in(fifo_byte),
    .fifo_empty(buf_empty), .take(start), .fifo_rd(fifo_rd), .blk_valid(blk_valid),
    .blk(blk), .blk_first(blk_first), .blk_last(blk_last));

  sha_round_core u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .first(blk_first), .last(blk_last),
    .blk(blk), .ready(core_ready), .fin(digest_valid), .digest(digest));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else if (go) busy <= 1'b1;
    else if (digest_valid) busy <= 1'b0;
  end

  a_r2_valid_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    digest_valid |-> busy);
  a_r2_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    digest_valid |=> !busy);
  a_r2_busy_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(len_load));
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    digest_valid |=> !digest_valid);
endmodule

// File: tb/sim_sha256_stream.sv
module sim_sha256_stream;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         len_load = 1'b0;
  logic [60:0]  len_bytes = '0;
  logic         wr_en = 1'b0;
  logic [7:0]   wr_byte = '0;
  logic         buf_empty, busy, digest_valid;
  logic [10:0]  buf_count;
  logic [255:0] digest;

  int checks = 0;
  int errors = 0;
  logic [7:0] msgb [0:511];

  always #(CLK_PERIOD/2) clk = ~clk;

  sha256_stream u0 (
    .clk(clk), .rst_n(rst_n), .len_load(len_load), .len_bytes(len_bytes),
    .wr_en(wr_en), .wr_byte(wr_byte), .buf_empty(buf_empty), .buf_count(buf_count),
    .busy(busy), .digest_valid(digest_valid), .digest(digest));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  // Independent reference: pads in a byte array, expands the full 64-word schedule
  function automatic logic [255:0] ref_digest(input int n);
    logic [31:0] kc [64] = '{
      32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
      32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
      32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
      32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
      32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
      32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
      32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
      32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};
    logic [7:0]  p [0:639];
    logic [31:0] hv [8] = '{32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                            32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
    logic [31:0] w [64];
    logic [31:0] a, b, c, d, e, f, g, h, t1, t2, s0, s1;
    logic [63:0] bitlen;
    int tot;
    tot = ((n + 8) / 64 + 1) * 64;
    bitlen = 64'(n) * 64'd8;
    for (int i = 0; i < tot; i++) p[i] = (i < n) ? msgb[i] : ((i == n) ? 8'h80 : 8'h00);
    for (int j = 0; j < 8; j++) p[tot-1-j] = 8'(bitlen >> (8*j));
    for (int bk = 0; bk < tot / 64; bk++) begin
      for (int t = 0; t < 16; t++)
        w[t] = {p[bk*64+4*t], p[bk*64+4*t+1], p[bk*64+4*t+2], p[bk*64+4*t+3]};
      for (int t = 16; t < 64; t++) begin
        s0 = rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3);
        s1 = rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10);
        w[t] = w[t-16] + s0 + w[t-7] + s1;
      end
      a = hv[0]; b = hv[1]; c = hv[2]; d = hv[3]; e = hv[4]; f = hv[5]; g = hv[6]; h = hv[7];
      for (int t = 0; t < 64; t++) begin
        t1 = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g)) + kc[t] + w[t];
        t2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
        h = g; g = f; f = e; e = d + t1; d = c; c = b; b = a; a = t1 + t2;
      end
      hv[0] += a; hv[1] += b; hv[2] += c; hv[3] += d;
      hv[4] += e; hv[5] += f; hv[6] += g; hv[7] += h;
    end
    return {hv[0], hv[1], hv[2], hv[3], hv[4], hv[5], hv[6], hv[7]};
  endfunction

  task automatic push_bytes(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b1; wr_byte = msgb[i];
      @(posedge clk); #1;
      wr_en = 1'b0;
      repeat (gap) begin @(posedge clk); #1; end
    end
  endtask

  function automatic void fill_pattern(input int n);
    for (int i = 0; i < n; i++) msgb[i] = 8'((i * 7 + n * 13 + 5) & 255);
  endfunction

  // prefill: bytes buffered before the load; timed: check the strobe cycle;
  // stray: extra load pulse while busy
  task automatic run_hash(input int n, input int gap, input bit prefill, input bit timed,
                          input bit stray, input string req, input logic [255:0] known,
                          input bit use_known);
    logic [255:0] exp;
    int cyc, nb;
    bit seen;
    exp = ref_digest(n);
    nb = (n + 8) / 64 + 1;
    if (prefill) begin
      push_bytes(n, 0);
      chk(buf_count == 11'(n), "R6", "buffer count after prefill", 256'(buf_count), 256'(n));
    end
    len_load = 1'b1; len_bytes = 61'(n);
    @(posedge clk); #1;
    len_load = 1'b0; len_bytes = '0;
    chk(busy == 1'b1, "R2", "busy after load", 256'(busy), 256'd1);
    if (stray) begin
      len_load = 1'b1; len_bytes = 61'd5;
      @(posedge clk); #1;
      len_load = 1'b0; len_bytes = '0;
    end
    if (!prefill) push_bytes(n, gap);
    cyc = prefill ? 0 : 1000000;
    seen = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      if (digest_valid) begin seen = 1'b1; break; end
      if (busy !== 1'b1) begin
        chk(1'b0, "R2", "busy dropped before digest", 256'(busy), 256'd1);
        break;
      end
      @(posedge clk); #1;
      cyc++;
    end
    chk(seen, req, "digest strobe seen", 256'(seen), 256'd1);
    if (seen) begin
      chk(digest == exp, req, "digest vs reference", digest, exp);
      if (use_known) chk(digest == known, req, "digest vs published value", digest, known);
      chk(busy == 1'b1, "R2", "busy during strobe", 256'(busy), 256'd1);
      if (timed)
        chk(cyc == 65 * nb + 64, "R7", "edges from load to strobe", 256'(cyc), 256'(65 * nb + 64));
      @(posedge clk); #1;
      chk(digest_valid == 1'b0, "R3", "strobe lasts one cycle", 256'(digest_valid), 256'd0);
      chk(busy == 1'b0, "R2", "busy low after strobe", 256'(busy), 256'd0);
      chk(buf_empty == 1'b1, "R6", "buffer drained", 256'(buf_empty), 256'd1);
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk(busy == 1'b0, "R1", "busy at reset", 256'(busy), 256'd0);
    chk(digest_valid == 1'b0, "R1", "strobe at reset", 256'(digest_valid), 256'd0);
    chk(buf_empty == 1'b1, "R1", "empty at reset", 256'(buf_empty), 256'd1);
    chk(buf_count == 11'd0, "R1", "count at reset", 256'(buf_count), 256'd0);
  endtask

  task automatic t_empty_msg;  // R5, R7
    run_hash(0, 0, 1'b1, 1'b1, 1'b0, "R5",
      256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855, 1'b1);
  endtask

  task automatic t_abc;  // R3, R8
    msgb[0] = 8'h61; msgb[1] = 8'h62; msgb[2] = 8'h63;
    run_hash(3, 2, 1'b0, 1'b0, 1'b0, "R3",
      256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad, 1'b1);
  endtask

  task automatic t_pad_edges;  // R4 block count boundary
    fill_pattern(55); run_hash(55, 0, 1'b1, 1'b1, 1'b0, "R4", '0, 1'b0);
    fill_pattern(56); run_hash(56, 0, 1'b1, 1'b1, 1'b0, "R4", '0, 1'b0);
    fill_pattern(64); run_hash(64, 0, 1'b1, 1'b1, 1'b0, "R4", '0, 1'b0);
  endtask

  task automatic t_stall_and_stray;  // R8, R9
    fill_pattern(200);
    run_hash(200, 3, 1'b0, 1'b0, 1'b1, "R9", '0, 1'b0);
  endtask

  task automatic t_long_prefill;  // R7, R6
    fill_pattern(300);
    run_hash(300, 0, 1'b1, 1'b1, 1'b0, "R7", '0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_empty_msg();
    t_abc();
    t_pad_edges();
    t_stall_and_stray();
    t_long_prefill();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule